// File: doc/BRIEF.md
# Timer Interrupt Status and Mask

This block gathers the interrupt events of a timer peripheral into one request line. Seven sources feed it: counter overflow, two periodic channels, two alarm channels, a clock-ready event and a ready event. Each event sets a sticky bit in a status register. That bit stays set until software clears it. A mask register decides which status bits can raise the request output. Software never writes the mask directly. It sets mask bits through a write-one-to-set port and clears them through a write-one-to-clear port.

The overflow, periodic and alarm inputs are single-cycle pulses from the event generators. The clock-ready and ready sources are different. They come from two busy flags, and the block detects when each flag falls from 1 to 0. The overflow bit has a second trigger: when the clear-on-alarm control input is high, any alarm match also sets it. Bus decoding stays outside the block. Each register port carries one cycle of write data, and an all-zero value means no write.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: A one in any bit of `mask_set_i` sets that bit of `mask_o` at the next clock edge. A zero bit leaves the mask bit unchanged.
- R2: A one in any bit of `mask_clr_i` clears that bit of `mask_o` at the next clock edge.
- R3: If `mask_set_i` and `mask_clr_i` both have a one in the same bit in one cycle, that mask bit ends up cleared.
- R4: A status bit stays set until a one is written to the same bit of `stat_clr_i`. It then clears at the next edge, unless R9 applies.
- R5: `irq_o` is high exactly when at least one bit is set in both `status_o` and `mask_o`. It follows those registers with no added delay.
- R6: The clock-ready status bit (bit 5) is set at the clock edge that first samples `clk_busy_i` low after it was sampled high. A rising edge or a steady level sets nothing.
- R7: The ready status bit (bit 6) is set the same way on a 1-to-0 transition of `busy_i`.
- R8: The overflow status bit (bit 0) is set by a pulse on `evt_ovf_i`. It is also set by any alarm pulse while `clr_on_alarm_i` is high. An alarm pulse while `clr_on_alarm_i` is low leaves bit 0 unchanged.
- R9: If a source event and a status clear hit the same bit in the same cycle, the bit stays set.
- R10: A synchronous active-high `rst` clears `mask_o` and `status_o` to all zeros, and so `irq_o` goes low.
- R11: The status and mask bits are ordered as follows: bit 0 overflow, bits 1 and 2 periodic channels 0 and 1, bits 3 and 4 alarm channels 0 and 1, bit 5 clock-ready, bit 6 ready.
- R12: A pulse on `evt_per_i[k]` sets status bit 1+k. A pulse on `evt_alarm_i[k]` sets status bit 3+k. Each takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_ovf_i | input | 1 | Counter overflow pulse |
| evt_per_i | input | 2 | Periodic channel pulses |
| evt_alarm_i | input | 2 | Alarm match pulses |
| clr_on_alarm_i | input | 1 | Clear-on-alarm control bit; routes alarm matches to the overflow status |
| clk_busy_i | input | 1 | Clock synchronization busy flag |
| busy_i | input | 1 | Register synchronization busy flag |
| mask_set_i | input | 7 | Write-one-to-set mask port |
| mask_clr_i | input | 7 | Write-one-to-clear mask port |
| stat_clr_i | input | 7 | Write-one-to-clear status port |
| mask_o | output | 7 | Current mask register |
| status_o | output | 7 | Current status register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks that a set and a clear of the same mask bit leave the bit cleared. A design that let the set win would raise an interrupt that software had just disabled. It also checks that an event arriving together with its own status clear keeps the bit set. A design that let the clear win would lose that event without any trace. The busy flags are driven through rising edges, steady levels and falling edges, so a detector that used the wrong polarity or fired on a level would set the clock-ready or ready bit at the wrong time. An alarm is sent both with and without clear-on-alarm, which catches wrong routing into the overflow bit. A status bit that is set while its mask bit is clear must keep the request low.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Bit positions of the status/mask vector for the default channel counts.
    typedef enum int unsigned {
        SRC_OVF    = 0,
        SRC_PER0   = 1,
        SRC_PER1   = 2,
        SRC_ALM0   = 3,
        SRC_ALM1   = 4,
        SRC_CLKRDY = 5,
        SRC_RDY    = 6
    } src_idx_e;

    // Total number of sources: overflow, periodic channels, alarm channels,
    // clock-ready and ready.
    function automatic int src_count(input int nper, input int nalm);
        return 1 + nper + nalm + 2;
    endfunction

    function automatic int per_base();
        return 1;
    endfunction

    function automatic int alm_base(input int nper);
        return 1 + nper;
    endfunction

    function automatic int clkrdy_pos(input int nper, input int nalm);
        return 1 + nper + nalm;
    endfunction

    function automatic int rdy_pos(input int nper, input int nalm);
        return 2 + nper + nalm;
    endfunction

endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    // High in the cycle where the flag is low after having been high.
    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/irq_event_map.sv
module irq_event_map
    import irq_pkg::*;
#(
    parameter int NPER = 2,
    parameter int NALM = 2,
    localparam int NSRC = src_count(NPER, NALM)
) (
    input  logic            ovf_i,
    input  logic [NPER-1:0] per_i,
    input  logic [NALM-1:0] alm_i,
    input  logic            clr_on_alarm_i,
    input  logic            clkrdy_i,
    input  logic            rdy_i,
    output logic [NSRC-1:0] evt_o
);
    localparam int PBASE = per_base();
    localparam int ABASE = alm_base(NPER);
    localparam int CPOS  = clkrdy_pos(NPER, NALM);
    localparam int RPOS  = rdy_pos(NPER, NALM);

    // Overflow: real overflow, or any alarm match when clear-on-alarm is set.
    assign evt_o[0] = ovf_i | (clr_on_alarm_i & (|alm_i));

    for (genvar p = 0; p < NPER; p++) begin : g_per
        assign evt_o[PBASE + p] = per_i[p];
    end

    for (genvar a = 0; a < NALM; a++) begin : g_alm
        assign evt_o[ABASE + a] = alm_i[a];
    end

    assign evt_o[CPOS] = clkrdy_i;
    assign evt_o[RPOS] = rdy_i;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Clear dominates set on a per-bit collision.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_i) & ~clr_i;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    // A new event dominates a clear of the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | evt_i;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NPER = 2,
    parameter int NALM = 2,
    localparam int NSRC = src_count(NPER, NALM)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            evt_ovf_i,
    input  logic [NPER-1:0] evt_per_i,
    input  logic [NALM-1:0] evt_alarm_i,
    input  logic            clr_on_alarm_i,
    input  logic            clk_busy_i,
    input  logic            busy_i,
    input  logic [NSRC-1:0] mask_set_i,
    input  logic [NSRC-1:0] mask_clr_i,
    input  logic [NSRC-1:0] stat_clr_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] busy_vec;
    logic [NFLAG-1:0] fall_vec;
    logic [NSRC-1:0]  evt_vec;

    assign busy_vec = {busy_i, clk_busy_i};

    for (genvar f = 0; f < NFLAG; f++) begin : g_fall
        irq_fall_det u_fall (
            .clk     (clk),
            .rst     (rst),
            .level_i (busy_vec[f]),
            .fall_o  (fall_vec[f])
        );
    end

    irq_event_map #(
        .NPER (NPER),
        .NALM (NALM)
    ) u_map (
        .ovf_i          (evt_ovf_i),
        .per_i          (evt_per_i),
        .alm_i          (evt_alarm_i),
        .clr_on_alarm_i (clr_on_alarm_i),
        .clkrdy_i       (fall_vec[0]),
        .rdy_i          (fall_vec[1]),
        .evt_o          (evt_vec)
    );

    irq_mask_reg #(
        .W (NSRC)
    ) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_i  (mask_set_i),
        .clr_i  (mask_clr_i),
        .mask_o (mask_o)
    );

    irq_status_reg #(
        .W (NSRC)
    ) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_vec),
        .clr_i  (stat_clr_i),
        .stat_o (status_o)
    );

    assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
    parameter int NPER = 2,
    parameter int NALM = 2,
    localparam int NSRC = irq_pkg::src_count(NPER, NALM)
) (
    input logic            clk,
    input logic            rst,
    input logic            evt_ovf_i,
    input logic [NPER-1:0] evt_per_i,
    input logic [NALM-1:0] evt_alarm_i,
    input logic            clr_on_alarm_i,
    input logic            clk_busy_i,
    input logic            busy_i,
    input logic [NSRC-1:0] mask_set_i,
    input logic [NSRC-1:0] mask_clr_i,
    input logic [NSRC-1:0] stat_clr_i,
    input logic [NSRC-1:0] mask_o,
    input logic [NSRC-1:0] status_o,
    input logic            irq_o
);
    localparam int CPOS = irq_pkg::clkrdy_pos(NPER, NALM);
    localparam int RPOS = irq_pkg::rdy_pos(NPER, NALM);

    a_r1_mask_set: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            ((mask_o & $past(mask_set_i & ~mask_clr_i)) == $past(mask_set_i & ~mask_clr_i)));

    a_r2_mask_clr: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((mask_o & $past(mask_clr_i)) == '0));

    a_r4_status_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((~status_o & $past(status_o) & ~$past(stat_clr_i)) == '0));

    a_r5_ovf_irq: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(evt_ovf_i) && $past(mask_o[0]) && !$past(mask_clr_i[0]))
            |-> irq_o);

    a_r6_clkrdy_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(clk_busy_i)) |=> status_o[CPOS]);

    a_r7_rdy_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy_i)) |=> status_o[RPOS]);

    a_r8_alarm_to_ovf: assert property (@(posedge clk) disable iff (rst)
        (clr_on_alarm_i && (|evt_alarm_i)) |=> status_o[0]);

    a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (evt_per_i[0] && stat_clr_i[1]) |=> status_o[1]);

    a_r10_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (status_o == '0 && mask_o == '0 && !irq_o));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(
    .NPER (NPER),
    .NALM (NALM)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .evt_ovf_i      (evt_ovf_i),
    .evt_per_i      (evt_per_i),
    .evt_alarm_i    (evt_alarm_i),
    .clr_on_alarm_i (clr_on_alarm_i),
    .clk_busy_i     (clk_busy_i),
    .busy_i         (busy_i),
    .mask_set_i     (mask_set_i),
    .mask_clr_i     (mask_clr_i),
    .stat_clr_i     (stat_clr_i),
    .mask_o         (mask_o),
    .status_o       (status_o),
    .irq_o          (irq_o)
);

// File: tb/tmr_irq_ctrl_test.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_test;

    typedef struct packed {
        logic       ovf;
        logic [1:0] per;
        logic [1:0] alm;
        logic       coa;
        logic       cbusy;
        logic       busy;
        logic [6:0] mset;
        logic [6:0] mclr;
        logic [6:0] sclr;
        logic [6:0] est;
        logic [6:0] emsk;
        logic       eirq;
    } vec_t;

    localparam int NV = 20;
    // Cumulative sequence; expected values after the edge that applies each row.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h7F, 7'h00, 7'h00, 7'h00, 7'h7F, 1'b0}, // R1
        '{1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h01, 7'h7F, 1'b1}, // R8 R5
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h01, 7'h7F, 1'b1}, // R4
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h01, 7'h00, 7'h7F, 1'b0}, // R4
        '{1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h02, 7'h7F, 1'b1}, // R12 R11
        '{1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h02, 7'h04, 7'h7F, 1'b1}, // R12
        '{1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h0C, 7'h7F, 1'b1}, // R8 no coa
        '{1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h1D, 7'h7F, 1'b1}, // R8 coa
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h7F, 7'h00, 7'h7F, 1'b0}, // R4
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 7'h00, 7'h00, 7'h00, 7'h00, 7'h7F, 1'b0}, // R6 R7 rise
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 7'h00, 7'h00, 7'h00, 7'h20, 7'h7F, 1'b1}, // R6 fall
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h60, 7'h7F, 1'b1}, // R7 fall
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h60, 7'h00, 7'h60, 7'h1F, 1'b0}, // R2 R5
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h40, 7'h40, 7'h00, 7'h60, 7'h1F, 1'b0}, // R3
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h20, 7'h00, 7'h00, 7'h60, 7'h3F, 1'b1}, // R1
        '{1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h02, 7'h62, 7'h3F, 1'b1}, // R9
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h62, 7'h00, 7'h3F, 1'b0}, // R4
        '{1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 7'h00, 7'h3E, 7'h00, 7'h09, 7'h01, 1'b1}, // R8 R2
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h01, 7'h08, 7'h01, 1'b0}, // R5 masked
        '{1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h00, 7'h00, 7'h08, 7'h00, 7'h01, 1'b0}  // R4
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_ovf_i = 1'b0;
    logic [1:0] evt_per_i = '0;
    logic [1:0] evt_alarm_i = '0;
    logic       clr_on_alarm_i = 1'b0;
    logic       clk_busy_i = 1'b0;
    logic       busy_i = 1'b0;
    logic [6:0] mask_set_i = '0;
    logic [6:0] mask_clr_i = '0;
    logic [6:0] stat_clr_i = '0;
    logic [6:0] mask_o;
    logic [6:0] status_o;
    logic       irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    tmr_irq_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .evt_ovf_i      (evt_ovf_i),
        .evt_per_i      (evt_per_i),
        .evt_alarm_i    (evt_alarm_i),
        .clr_on_alarm_i (clr_on_alarm_i),
        .clk_busy_i     (clk_busy_i),
        .busy_i         (busy_i),
        .mask_set_i     (mask_set_i),
        .mask_clr_i     (mask_clr_i),
        .stat_clr_i     (stat_clr_i),
        .mask_o         (mask_o),
        .status_o       (status_o),
        .irq_o          (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        evt_ovf_i      = v.ovf;
        evt_per_i      = v.per;
        evt_alarm_i    = v.alm;
        clr_on_alarm_i = v.coa;
        clk_busy_i     = v.cbusy;
        busy_i         = v.busy;
        mask_set_i     = v.mset;
        mask_clr_i     = v.mclr;
        stat_clr_i     = v.sclr;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        apply('0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 status", 32'(status_o), 32'h0);
        check("R10 mask", 32'(mask_o), 32'h0);
        check("R10 irq", 32'(irq_o), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R1-R12 vec%0d status", i), 32'(status_o), 32'(VEC[i].est));
            check($sformatf("R1 R2 R3 vec%0d mask", i), 32'(mask_o), 32'(VEC[i].emsk));
            check($sformatf("R5 vec%0d irq", i), 32'(irq_o), 32'(VEC[i].eirq));
        end

        // R6 R7: steady high busy flags for several cycles set nothing.
        clk_busy_i = 1'b1;
        busy_i     = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check("R6 R7 steady high", 32'(status_o), 32'h0);
        clk_busy_i = 1'b0;
        busy_i     = 1'b0;
        @(posedge clk);
        #1;
        check("R6 R7 simultaneous fall", 32'(status_o), 32'h60);
        idle();
        check("R6 R7 steady low no re-trigger", 32'(status_o), 32'h60);

        // R9: alarm event beats clear on bit 3.
        apply('{1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 7'h7F, 7'h00, 7'h68,
                7'h08, 7'h7F, 1'b1});
        check("R9 alarm vs clear", 32'(status_o), 32'h08);
        check("R5 irq after unmask", 32'(irq_o), 32'h1);

        // R10: mid-run reset clears everything.
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R10 mid status", 32'(status_o), 32'h0);
        check("R10 mid mask", 32'(mask_o), 32'h0);
        check("R10 mid irq", 32'(irq_o), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule